// File: doc/BRIEF.md
# Double-Sampling Timing-Error Register

This block is a bank of pipeline register bits that sample their input twice. A main flop captures the data word on the rising edge of the stage clock. A shadow element captures the same word again on the rising edge of a second clock. That second clock is a delayed copy of the stage clock and lands later in the same cycle. If logic feeding the register settles late, the two samples differ. The shadow value is taken as the correct one, because the delay is chosen so that even slow paths have settled before the late edge.

At the next stage-clock edge the block compares the two samples. On any difference it loads the whole word from the shadow element in place of the new input, so the stage keeps moving with correct data. In the same edge it raises registered error outputs: a per-bit mismatch vector, a stage-wide flag, and an active-low copy of that flag. The flag also feeds a second register stage, which gives recovery logic a copy that has had an extra cycle to settle. Upstream logic is expected to hold its next item for one cycle after an error. For that reason the comparison is skipped in the cycle that follows a correction.

The block relies on a hold rule: the shortest path into the register must be longer than the clock delay plus the hold time. If it is not, the shadow sample picks up the next cycle's data. That rule is met by the surrounding design and is not checked here.

Top module: `dsr_bank`

## Requirements
- R1: While the synchronous, active-high `rst` is sampled high, the main and shadow samples are cleared. After the next `clk` edge, `q`, `err_bits`, `err` and `err_sync` read zero and `err_n` reads one.
- R2: When `d` is stable across both the `clk` edge and the following `clk_del` edge, `q` shows that value after the `clk` edge. No error output rises at the next comparison.
- R3: When the main and shadow samples differ at a `clk` edge, outside the cycle after a correction, the main flop loads the shadow value for the whole word instead of `d`. `q` then shows the late value.
- R4: At a correcting edge, `err_bits` bit i is set exactly when bit i of the early sample differs from bit i of the late sample. In the same edge `err` becomes one and `err_n` becomes zero. Outside a correcting edge, `err_bits` is zero, `err` is zero and `err_n` is one.
- R5: In the `clk` cycle after a correction, the main flop loads `d` whatever the shadow holds. `err` stays zero in that cycle, so `err` is never high on two edges in a row.
- R6: `err_sync` equals the value `err` had one `clk` edge earlier. After reset it starts from zero.
- R7: A reset that arrives while a mismatch is pending cancels the correction. `q` reads zero and no error output rises for that mismatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stage clock; main samples and all outputs change on its rising edge |
| clk_del | input | 1 | Delayed copy of `clk`; its rising edge takes the late sample |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| d | input | WIDTH | Data word from the preceding logic |
| q | output | WIDTH | Register output (main sample, corrected when needed) |
| err_bits | output | WIDTH | Per-bit mismatch vector of the last correcting edge |
| err | output | 1 | Stage-wide timing-error flag, registered |
| err_n | output | 1 | Active-low copy of `err` |
| err_sync | output | 1 | `err` passed through one more register stage for recovery logic |

## Verification
Several properties are checked on every clock cycle. A mismatch outside the cycle after a correction must load the late sample. Errors can never appear on two consecutive edges. The aggregate flag must agree with the bit vector and its active-low copy. The second-stage flag must trail the first by one edge. Only the bench scenarios can show the end-to-end effect of an input arriving between the two clock edges. They check the exact mismatch pattern in the error vector and the word that reaches `q` in the cycle after a correction. They also check that a reset arriving mid-error really discards the pending correction.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  // Source chosen by the main-flop input mux
  typedef enum logic {
    SEL_D      = 1'b0,
    SEL_SHADOW = 1'b1
  } dsr_sel_e;

  // Fewest register stages the error flag passes through
  localparam int unsigned DSR_MIN_SYNC = 2;

endpackage

// File: rtl/dsr_cell.sv
module dsr_cell
  import dsr_pkg::*;
(
  input  logic     clk,
  input  logic     clk_del,
  input  logic     rst,
  input  logic     d,
  input  dsr_sel_e sel,
  output logic     main_q,
  output logic     shadow_q,
  output logic     diff
);

  // Early sample; takes the late sample instead when the controller corrects
  always_ff @(posedge clk) begin
    if (rst)
      main_q <= 1'b0;
    else if (sel == SEL_SHADOW)
      main_q <= shadow_q;
    else
      main_q <= d;
  end

  // Late sample, taken on the delayed edge within the same cycle
  always_ff @(posedge clk_del) begin
    if (rst)
      shadow_q <= 1'b0;
    else
      shadow_q <= d;
  end

  assign diff = main_q ^ shadow_q;

endmodule

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] diff,
  output dsr_sel_e         sel,
  output logic             skip_q,
  output logic [WIDTH-1:0] err_bits,
  output logic             err,
  output logic             err_n,
  output logic             err_sync
);

  localparam int unsigned NSTG = (SYNC_STAGES < DSR_MIN_SYNC) ? DSR_MIN_SYNC : SYNC_STAGES;

  logic            any_diff;
  logic            corr;
  logic [NSTG-1:0] stg;

  assign any_diff = |diff;
  // The cycle after a correction holds replayed input; comparing it is meaningless
  assign corr     = any_diff & ~skip_q;
  assign sel      = corr ? SEL_SHADOW : SEL_D;

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q   <= 1'b0;
      err_bits <= '0;
      err      <= 1'b0;
      err_n    <= 1'b1;
    end else begin
      skip_q   <= corr;
      err_bits <= corr ? diff : '0;
      err      <= corr;
      err_n    <= ~corr;
    end
  end

  // Error flag register chain for recovery logic
  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= corr;
      for (int i = 1; i < int'(NSTG); i++)
        stg[i] <= stg[i-1];
    end
  end

  assign err_sync = stg[NSTG-1];

endmodule

// File: rtl/dsr_bank.sv
module dsr_bank
  import dsr_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clk_del,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] err_bits,
  output logic             err,
  output logic             err_n,
  output logic             err_sync
);

  logic [WIDTH-1:0] main_vec;
  logic [WIDTH-1:0] shadow_vec;
  logic [WIDTH-1:0] diff_vec;
  dsr_sel_e         sel;
  logic             skip_q;

  for (genvar b = 0; b < int'(WIDTH); b++) begin : g_bit
    dsr_cell u_cell (
      .clk      (clk),
      .clk_del  (clk_del),
      .rst      (rst),
      .d        (d[b]),
      .sel      (sel),
      .main_q   (main_vec[b]),
      .shadow_q (shadow_vec[b]),
      .diff     (diff_vec[b])
    );
  end

  dsr_ctrl #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .diff     (diff_vec),
    .sel      (sel),
    .skip_q   (skip_q),
    .err_bits (err_bits),
    .err      (err),
    .err_n    (err_n),
    .err_sync (err_sync)
  );

  assign q = main_vec;

endmodule

// File: rtl/dsr_bank_chk.sv
module dsr_bank_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] q,
  input logic [WIDTH-1:0] shadow,
  input logic             skip,
  input logic [WIDTH-1:0] err_bits,
  input logic             err,
  input logic             err_n,
  input logic             err_sync
);

  // R3
  late_sample_loaded_chk: assert property (@(posedge clk) disable iff (rst)
    ((q != shadow) && !skip) |=> (q == $past(shadow)));

  // R4
  flag_matches_bits_chk: assert property (@(posedge clk) disable iff (rst)
    err == (err_bits != '0));

  // R4
  low_copy_chk: assert property (@(posedge clk) disable iff (rst)
    err_n == !err);

  // R5
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R6
  second_stage_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (err_sync == $past(err)));

endmodule

bind dsr_bank dsr_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .q        (q),
  .shadow   (shadow_vec),
  .skip     (skip_q),
  .err_bits (err_bits),
  .err      (err),
  .err_n    (err_n),
  .err_sync (err_sync)
);

// File: tb/tb_dsr_bank.sv
module tb_dsr_bank;

  localparam int CLK_PERIOD = 10;
  localparam int DEL        = 3;
  localparam int W          = 8;

  logic         clk, clk_del, rst;
  logic [W-1:0] d, q, err_bits;
  logic         err, err_n, err_sync;
  int           checks = 0;
  int           errors = 0;
  bit           done   = 0;

  dsr_bank #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .clk_del(clk_del), .rst(rst), .d(d), .q(q),
    .err_bits(err_bits), .err(err), .err_n(err_n), .err_sync(err_sync)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    clk_del = 1'b0;
    #(DEL);
    forever #(CLK_PERIOD/2) clk_del = ~clk_del;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic settle(input logic [W-1:0] v);
    @(posedge clk); #6 d = v;
    @(posedge clk); #6;
  endtask

  // R1: reset state
  task automatic t_reset();
    rst = 1'b1; d = 8'hFF;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "q", 32'(q), 32'h0);
    chk("R1", "err_bits", 32'(err_bits), 32'h0);
    chk("R1", "err", 32'(err), 32'h0);
    chk("R1", "err_n", 32'(err_n), 32'h1);
    chk("R1", "err_sync", 32'(err_sync), 32'h0);
    #4 rst = 1'b0; d = 8'h00;
  endtask

  // R2: clean stream, each value stable through both samples
  task automatic t_stream();
    logic [W-1:0] vals [5] = '{8'h01, 8'hFE, 8'h5A, 8'hC3, 8'h80};
    foreach (vals[i]) begin
      @(posedge clk); #6 d = vals[i];
      @(posedge clk); #2;
      chk("R2", "q", 32'(q), 32'(vals[i]));
      chk("R2", "err", 32'(err), 32'h0);
    end
  endtask

  // R3/R4/R5/R6: early value x, late value l, next item n
  task automatic t_late(input logic [W-1:0] p, input logic [W-1:0] x,
                        input logic [W-1:0] l, input logic [W-1:0] n);
    settle(p);
    d = x;                       // E0+6
    @(posedge clk); #1 d = l;    // E1+1, before delayed edge
    #1 chk("R3", "q early", 32'(q), 32'(x));
    #4 d = n;                    // E1+6
    @(posedge clk); #2;          // E2
    chk("R3", "q corrected", 32'(q), 32'(l));
    chk("R4", "err_bits", 32'(err_bits), 32'(x ^ l));
    chk("R4", "err", 32'(err), 32'h1);
    chk("R4", "err_n", 32'(err_n), 32'h0);
    chk("R6", "err_sync lag", 32'(err_sync), 32'h0);
    @(posedge clk); #2;          // E3: suppressed compare
    chk("R5", "q loads d", 32'(q), 32'(n));
    chk("R5", "err low", 32'(err), 32'h0);
    chk("R5", "err_bits low", 32'(err_bits), 32'h0);
    chk("R6", "err_sync", 32'(err_sync), 32'h1);
    @(posedge clk); #2;          // E4
    chk("R6", "err_sync clear", 32'(err_sync), 32'h0);
    chk("R2", "q steady", 32'(q), 32'(n));
    chk("R2", "err steady", 32'(err), 32'h0);
  endtask

  // R7: reset arrives with a mismatch pending
  task automatic t_reset_mid();
    settle(8'h22);
    d = 8'h0F;
    @(posedge clk); #1 d = 8'hF0;
    #5 rst = 1'b1; d = 8'h99;
    @(posedge clk); #2;
    chk("R7", "q", 32'(q), 32'h0);
    chk("R7", "err", 32'(err), 32'h0);
    chk("R7", "err_bits", 32'(err_bits), 32'h0);
    #4 rst = 1'b0;
    @(posedge clk); #2;
    chk("R7", "q after", 32'(q), 32'h99);
    chk("R7", "err after", 32'(err), 32'h0);
    @(posedge clk); #2;
    chk("R7", "err_sync", 32'(err_sync), 32'h0);
  endtask

  initial begin
    rst = 1'b1; d = '0;
    t_reset();
    t_stream();
    t_late(8'h11, 8'hA5, 8'hA4, 8'h5A);
    t_late(8'h3C, 8'h0F, 8'hF0, 8'h33);
    t_late(8'h00, 8'h81, 8'h00, 8'h7E);
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule